// File: doc/BRIEF.md
# Interrupt Deactivation Permission Checker

This block sits on the write path of an interrupt controller's per-processor interface and judges each explicit "deactivate this interrupt" write. It does not own the active-state storage; it decides whether a write may clear the active state of the named interrupt and, if so, sends a single-cycle deactivate strobe with the interrupt number to the storage that does.

The decision has two stages. First, the write must name an implemented interrupt, and the interface must be in split mode, where priority drop and deactivation are separate operations. Second, a permission matrix is applied. Its inputs are the interrupt's group and security, the global single-security mode, the requester's exception level (1 to 3), whether a level-1 requester is secure, and four routing bits. These bits say whether FIQ or IRQ is taken to the top level or to the hypervisor level. A requester may only deactivate interrupts that it could itself have been handed.

The group is a 2-bit code on `grp`. Code 0 is group 0, code 1 is secure group 1, code 2 is non-secure group 1, and code 3 is reserved.

Top module: `dact_checker`

## Requirements
- R1: During and right after a synchronous active-low reset, `deact_vld` is 0 and `deact_id` is 0.
- R2: The interrupt number is `wr_data[23:0]`. Bits 31:24 have no effect. A write whose number is at or above `NUM_INTR` (default 1020) never produces a strobe.
- R3: When `split_eoi` is 0 in the write cycle, the write never produces a strobe.
- R4: At level 3 (`cur_lvl` = 3), every write that passes R2 and R3 and carries a group code of 0, 1 or 2 produces a strobe.
- R5: At level 2, a strobe is produced only if (`single_sec` and group 0 and not `fiq_to_top`) or (the interrupt is non-secure, its group is not 0, and not `irq_to_top`).
- R6: At non-secure level 1 (`sec_lower` = 0), a strobe is produced only if (`single_sec` and group 0 and neither `fiq_to_top` nor `fiq_to_hyp`) or (the interrupt is non-secure, its group is not 0, and neither `irq_to_top` nor `irq_to_hyp`).
- R7: At secure level 1 (`sec_lower` = 1), a strobe is produced only if (group 0 and not `fiq_to_top`) or (group not 0, and (interrupt non-secure or not `single_sec`), and not `irq_to_top`).
- R8: An interrupt counts as secure exactly when `single_sec` is 0 and its group code is not 2.
- R9: Level 0 and group code 3 never produce a strobe.
- R10: A permitted write at clock edge N makes `deact_vld` 1 for the cycle after edge N, with `deact_id` equal to the number. With no permitted write at edge N, `deact_vld` and `deact_id` are 0 after edge N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Deactivate write strobe |
| wr_data | input | 32 | Write value; interrupt number in bits 23:0 |
| grp | input | 2 | Group code of the named interrupt (0 G0, 1 secure G1, 2 non-secure G1, 3 reserved) |
| split_eoi | input | 1 | Split priority-drop/deactivate mode enabled |
| single_sec | input | 1 | Controller runs with a single security state |
| cur_lvl | input | 2 | Requester exception level |
| sec_lower | input | 1 | Requester below the top level is secure |
| fiq_to_top | input | 1 | FIQ routed to level 3 |
| irq_to_top | input | 1 | IRQ routed to level 3 |
| fiq_to_hyp | input | 1 | FIQ routed to level 2 |
| irq_to_hyp | input | 1 | IRQ routed to level 2 |
| deact_vld | output | 1 | One-cycle deactivate strobe |
| deact_id | output | 24 | Interrupt number to deactivate, 0 when no strobe |

## Verification
The permission matrix is tried against every combination of group code, single-security mode, level, requester security, the four routing bits and split mode. This separates each clause of R5 to R7 from its neighbours: a route bit that one level consults and another ignores shows up as a mismatch at one level only. A second pattern sets the number to the values on either side of `NUM_INTR` and to the largest 24-bit value, with junk in the upper bits, to separate the range compare from the field extraction. Idle cycles between writes, and a write held for two cycles, show that the strobe is a pulse tied to each write.

// File: rtl/dact_pkg.sv
// Shared encodings for the deactivation permission checker.
// Assumes a 2-bit group code and a 2-bit exception level.
package dact_pkg;
    typedef enum logic [1:0] {
        GRP_ZERO  = 2'd0,
        GRP_ONE_S = 2'd1,
        GRP_ONE_N = 2'd2,
        GRP_RSVD  = 2'd3
    } grp_e;

    typedef enum logic [1:0] {
        LVL_USER = 2'd0,
        LVL_KERN = 2'd1,
        LVL_HYP  = 2'd2,
        LVL_TOP  = 2'd3
    } lvl_e;

    typedef struct packed {
        logic fiq_top;
        logic irq_top;
        logic fiq_hyp;
        logic irq_hyp;
    } route_t;
endpackage

// File: rtl/dact_id_filter.sv
// Extracts the interrupt number from the write value and reports whether
// it names an implemented interrupt. Assumes ID_W <= DATA_W.
module dact_id_filter #(
    parameter int DATA_W   = 32,
    parameter int ID_W     = 24,
    parameter int NUM_INTR = 1020
) (
    input  logic [DATA_W-1:0] data_in,
    output logic [ID_W-1:0]   id_out,
    output logic              in_range
);
    localparam logic [ID_W-1:0] LIMIT = ID_W'(NUM_INTR);

    // Field extraction and range compare.
    always_comb begin
        id_out   = data_in[ID_W-1:0];
        in_range = (id_out < LIMIT);
    end
endmodule

// File: rtl/dact_perm_matrix.sv
// Level-dependent permission matrix. Purely combinational; assumes the
// caller has already applied the range and split-mode gates.
module dact_perm_matrix
    import dact_pkg::*;
(
    input  grp_e   grp_i,
    input  logic   single_sec,
    input  lvl_e   lvl_i,
    input  logic   sec_lower,
    input  route_t route,
    output logic   permit
);
    logic is_g0, is_sec, grp_ok;
    logic ok_hyp, ok_kern_ns, ok_kern_s;

    // Classify the interrupt.
    always_comb begin
        is_g0  = (grp_i == GRP_ZERO);
        grp_ok = (grp_i != GRP_RSVD);
        is_sec = !single_sec && (grp_i != GRP_ONE_N);
    end

    // Per-level rule terms.
    always_comb begin
        ok_hyp     = (single_sec && is_g0 && !route.fiq_top) ||
                     (!is_sec && !is_g0 && !route.irq_top);
        ok_kern_ns = (single_sec && is_g0 && !route.fiq_top && !route.fiq_hyp) ||
                     (!is_sec && !is_g0 && !route.irq_top && !route.irq_hyp);
        ok_kern_s  = (is_g0 && !route.fiq_top) ||
                     (!is_g0 && (!is_sec || !single_sec) && !route.irq_top);
    end

    // Select by level.
    always_comb begin
        unique case (lvl_i)
            LVL_TOP:  permit = grp_ok;
            LVL_HYP:  permit = grp_ok && ok_hyp;
            LVL_KERN: permit = grp_ok && (sec_lower ? ok_kern_s : ok_kern_ns);
            default:  permit = 1'b0;
        endcase
    end

    // Level 3 with a valid group is always allowed.
    always_comb begin
        if (lvl_i == LVL_TOP && grp_i != GRP_RSVD)
            AST_TOP_ALWAYS: assert (permit); // R4
    end
endmodule

// File: rtl/dact_strobe_reg.sv
// Output stage: registers the pulse and number. Assumes the number is
// forced to zero when there is no strobe.
module dact_strobe_reg #(
    parameter int ID_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire,
    input  logic [ID_W-1:0] id_in,
    output logic            vld_q,
    output logic [ID_W-1:0] id_q
);
    // Capture one pulse per permitted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            id_q  <= '0;
        end else begin
            vld_q <= fire;
            id_q  <= fire ? id_in : '0;
        end
    end
endmodule

// File: rtl/dact_checker.sv
// Top: gates an explicit deactivate write by range, split mode and the
// permission matrix, then emits a registered one-cycle strobe.
module dact_checker
    import dact_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ID_W     = 24,
    parameter int NUM_INTR = 1020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        grp,
    input  logic              split_eoi,
    input  logic              single_sec,
    input  logic [1:0]        cur_lvl,
    input  logic              sec_lower,
    input  logic              fiq_to_top,
    input  logic              irq_to_top,
    input  logic              fiq_to_hyp,
    input  logic              irq_to_hyp,
    output logic              deact_vld,
    output logic [ID_W-1:0]   deact_id
);
    logic [ID_W-1:0] id_w;
    logic            in_range;
    logic            permit;
    logic            fire;
    route_t          route;

    // Bundle routing bits.
    always_comb begin
        route.fiq_top = fiq_to_top;
        route.irq_top = irq_to_top;
        route.fiq_hyp = fiq_to_hyp;
        route.irq_hyp = irq_to_hyp;
    end

    dact_id_filter #(
        .DATA_W  (DATA_W),
        .ID_W    (ID_W),
        .NUM_INTR(NUM_INTR)
    ) u_filter (
        .data_in (wr_data),
        .id_out  (id_w),
        .in_range(in_range)
    );

    dact_perm_matrix u_matrix (
        .grp_i     (grp_e'(grp)),
        .single_sec(single_sec),
        .lvl_i     (lvl_e'(cur_lvl)),
        .sec_lower (sec_lower),
        .route     (route),
        .permit    (permit)
    );

    // Combine all gates.
    always_comb fire = wr_en && in_range && split_eoi && permit;

    dact_strobe_reg #(.ID_W(ID_W)) u_out (
        .clk  (clk),
        .rst_n(rst_n),
        .fire (fire),
        .id_in(id_w),
        .vld_q(deact_vld),
        .id_q (deact_id)
    );

    AST_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        deact_vld |-> $past(wr_en)); // R10
    AST_ID_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        deact_vld |-> (deact_id < ID_W'(NUM_INTR))); // R2
    AST_NEEDS_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        deact_vld |-> $past(split_eoi)); // R3
    AST_NO_LVL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        deact_vld |-> ($past(cur_lvl) != 2'd0)); // R9
    AST_ID_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !deact_vld |-> (deact_id == '0)); // R10
endmodule

// File: tb/dact_checker_tb.sv
module dact_checker_tb;
    localparam int NUM = 1020;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  grp = '0;
    logic        split_eoi = 1'b0, single_sec = 1'b0, sec_lower = 1'b0;
    logic [1:0]  cur_lvl = '0;
    logic        fiq_to_top = 1'b0, irq_to_top = 1'b0, fiq_to_hyp = 1'b0, irq_to_hyp = 1'b0;
    logic        deact_vld;
    logic [23:0] deact_id;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    dact_checker u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .grp(grp),
        .split_eoi(split_eoi), .single_sec(single_sec), .cur_lvl(cur_lvl),
        .sec_lower(sec_lower), .fiq_to_top(fiq_to_top), .irq_to_top(irq_to_top),
        .fiq_to_hyp(fiq_to_hyp), .irq_to_hyp(irq_to_hyp),
        .deact_vld(deact_vld), .deact_id(deact_id)
    );

    // Reference rule set, written from the requirements.
    function automatic bit model(input int g, input bit ss, input int lv, input bit sl,
                                 input bit ft, input bit it, input bit fh, input bit ih,
                                 input bit sp, input int id);
        bit g0, sec;
        if (id >= NUM || !sp || g == 3) return 0;      // R2 R3 R9
        g0  = (g == 0);
        sec = !ss && (g != 2);                         // R8
        case (lv)
            3: return 1;                               // R4
            2: return (ss && g0 && !ft) || (!sec && !g0 && !it);  // R5
            1: if (!sl) return (ss && g0 && !ft && !fh) || (!sec && !g0 && !it && !ih); // R6
               else return (g0 && !ft) || (!g0 && (!sec || !ss) && !it);              // R7
            default: return 0;                         // R9
        endcase
    endfunction

    task automatic check(input string req, input bit ev, input int eid);
        total++;
        if (deact_vld !== ev || deact_id !== 24'(eid)) begin
            bad++;
            $display("FAIL %s: vld=%0b id=%0d expected vld=%0b id=%0d",
                     req, deact_vld, deact_id, ev, eid);
        end
    endtask

    // One write cycle; result checked one cycle later.
    task automatic do_write(input string req, input int g, input bit ss, input int lv,
                            input bit sl, input int rt, input bit sp, input logic [31:0] d);
        bit ev;
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; grp = 2'(g); single_sec = ss; cur_lvl = 2'(lv);
        sec_lower = sl; split_eoi = sp;
        {fiq_to_top, irq_to_top, fiq_to_hyp, irq_to_hyp} = 4'(rt);
        ev = model(g, ss, lv, sl, rt[3], rt[2], rt[1], rt[0], sp, int'(d[23:0]));
        @(negedge clk);
        wr_en = 1'b0;
        check(req, ev, ev ? int'(d[23:0]) : 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check("R1 reset", 1'b0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 1'b0, 0);

        // Exhaustive sweep of the permission matrix (R3..R9).
        for (int sp = 0; sp < 2; sp++)
            for (int lv = 0; lv < 4; lv++)
                for (int sl = 0; sl < 2; sl++)
                    for (int ss = 0; ss < 2; ss++)
                        for (int g = 0; g < 4; g++)
                            for (int rt = 0; rt < 16; rt++)
                                do_write("R3-sweep R4 R5 R6 R7 R8 R9", g, ss[0], lv, sl[0], rt, sp[0],
                                         32'(((lv * 131) + (g * 37) + rt * 7 + ss + sl * 3) % NUM));

        // Number boundaries with junk upper bits (R2).
        do_write("R2 id0",   0, 1'b1, 3, 1'b0, 0, 1'b1, 32'hAB00_0000);
        do_write("R2 last",  2, 1'b0, 3, 1'b0, 0, 1'b1, 32'hFF00_0000 | (NUM - 1));
        do_write("R2 limit", 1, 1'b0, 3, 1'b0, 0, 1'b1, 32'h5A00_0000 | NUM);
        do_write("R2 1023",  0, 1'b0, 3, 1'b1, 0, 1'b1, 32'd1023);
        do_write("R2 max",   0, 1'b0, 3, 1'b1, 0, 1'b1, 32'h00FF_FFFF);

        // Pulse: idle cycle after a permitted write (R10).
        do_write("R10 write", 2, 1'b0, 3, 1'b0, 0, 1'b1, 32'd77);
        @(negedge clk);
        check("R10 idle after strobe", 1'b0, 0);

        // Held write yields one strobe per cycle, then drops (R10).
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'd5; grp = 2'd0; cur_lvl = 2'd3; split_eoi = 1'b1;
        @(negedge clk);
        check("R10 held 1", 1'b1, 5);
        wr_data = 32'd6;
        @(negedge clk);
        check("R10 held 2", 1'b1, 6);
        wr_en = 1'b0;
        @(negedge clk);
        check("R10 released", 1'b0, 0);

        // Reset mid-strobe clears outputs (R1).
        wr_en = 1'b1; wr_data = 32'd9;
        @(negedge clk);
        wr_en = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears", 1'b0, 0);
        rst_n = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule